// File: doc/BRIEF.md
# Programmable Chip-Select Area Decoder

This block sits between an internal bus master and the bus cycle generator that drives external memory and I/O devices. Every access request carries an address and a read/write flag. The block compares that address against a bank of independently configured windows. Each window has a base address, a power-of-two size, an enable bit and a set of per-window access attributes.

On a match, the block raises the chip select for the winning window. It also hands that window's attributes to the cycle generator: timing type, data width, byte order and maximum burst length. Two cases are refused and end with an error pulse and no external strobe: an access that lands in no enabled window, and a write to a window that forbids writes.

Results are registered, so the decode adds exactly one cycle. The configuration inputs are treated as quasi-static register contents.

Top module: `csel_decoder`

## Requirements
- R1: A request sampled at a rising clock edge produces its results in the outputs right after the next rising edge. A cycle without a request leaves chip selects, hit and error all low in the following cycle.
- R2: Window i matches when its enable bit is set and the address bits at positions s and above equal the same bits of its base. Here s is the window's 5-bit size code clamped to the range 16..31, so the window covers 2^s bytes (64 KB to 2 GB).
- R3: Base bits below position s have no effect, so every window is naturally aligned to its own size.
- R4: A disabled window never matches. A request that matches no enabled window yields err=1, hit=0, all chip selects low and all attribute outputs zero.
- R5: When several enabled windows match, the lowest-numbered one is selected and reported on the window index output.
- R6: On an accepted access, exactly one chip select is high, and it is the bit equal to the reported window index.
- R7: A write to a window whose write-prohibit bit is set yields err=1, hit=1, the window index and its attributes, with no chip select. A read of the same window is accepted normally.
- R8: The width output copies the window's width bit (0 = 8-bit, 1 = 16-bit). The 2-bit timing output copies the window's timing type.
- R9: The byte-order output copies the window's endian bit (1 = big, 0 = little). Window 0 always reports big endian, whatever its bit holds.
- R10: The burst output is the value 1, 2, 4 or 8 for the window's 2-bit burst code 0, 1, 2 or 3, so it has exactly one bit set on any hit.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Access address |
| cfg_en_i | input | 8 | Per-window enable |
| cfg_wprot_i | input | 8 | Per-window write-prohibit |
| cfg_big_i | input | 8 | Per-window big-endian bit (bit 0 ignored) |
| cfg_w16_i | input | 8 | Per-window 16-bit data width |
| cfg_base_i | input | 256 | Window bases, window i at bits [32i+31:32i] |
| cfg_size_i | input | 40 | Size codes (log2 bytes), window i at bits [5i+4:5i] |
| cfg_timing_i | input | 16 | Timing types, window i at bits [2i+1:2i] |
| cfg_burst_i | input | 16 | Burst codes, window i at bits [2i+1:2i] |
| cs_o | output | 8 | One-hot chip selects |
| hit_o | output | 1 | An enabled window matched |
| win_o | output | 3 | Selected window index |
| err_o | output | 1 | One-cycle error pulse (miss or refused write) |
| timing_o | output | 2 | Timing type of the selected window |
| w16_o | output | 1 | 16-bit width of the selected window |
| big_o | output | 1 | Big-endian byte order of the selected window |
| burst_len_o | output | 4 | Maximum burst length (1, 2, 4 or 8) |

## Verification
The assertions assume that reset, request and write inputs are always known. They also assume the configuration never changes in the same cycle as a request, because results are judged against the request of the previous edge. The stimulus obeys this by rewriting window settings only in idle cycles, with the request low. Every access is launched on a falling edge and withdrawn one cycle later, so each result is observed alone. The sweeps probe both edges of every window and the addresses just outside them. They also cover overlapping, disabled, misaligned-base and out-of-range-size windows.

// File: rtl/csel_pkg.sv
package csel_pkg;
   localparam int CSEL_TIMING_W   = 2;
   localparam int CSEL_BURST_CW   = 2;
   localparam int CSEL_BURST_LENW = 1 << CSEL_BURST_CW;

   typedef struct packed {
      logic [CSEL_TIMING_W-1:0]   timing;
      logic                       w16;
      logic                       big;
      logic [CSEL_BURST_LENW-1:0] burst_len;
   } csel_attr_t;
endpackage

// File: rtl/csel_win_match.sv
module csel_win_match #(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 5,
   parameter int MIN_LOG2 = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              en_i,
   output logic              match_o
);
   localparam int MAX_LOG2 = ADDR_W - 1;

   logic [SIZE_W-1:0] span;
   logic [ADDR_W-1:0] keep;

   always_comb begin
      if (size_i < SIZE_W'(MIN_LOG2))      span = SIZE_W'(MIN_LOG2);
      else if (size_i > SIZE_W'(MAX_LOG2)) span = SIZE_W'(MAX_LOG2);
      else                                 span = size_i;
      for (int b = 0; b < ADDR_W; b++) begin
         keep[b] = (b >= int'(span));
      end
      match_o = en_i && (((addr_i ^ base_i) & keep) == '0);
   end
endmodule

// File: rtl/csel_prio_pick.sv
module csel_prio_pick #(
   parameter int NUM_WIN = 8,
   localparam int IDX_W  = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0] match_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (match_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
   import csel_pkg::*;
#(
   parameter int NUM_WIN  = 8,
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 5,
   parameter int MIN_LOG2 = 16,
   localparam int IDX_W   = $clog2(NUM_WIN),
   localparam int TW      = CSEL_TIMING_W,
   localparam int BCW     = CSEL_BURST_CW,
   localparam int BLW     = CSEL_BURST_LENW
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  req_i,
   input  logic                  wr_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [NUM_WIN-1:0]    cfg_en_i,
   input  logic [NUM_WIN-1:0]    cfg_wprot_i,
   input  logic [NUM_WIN-1:0]    cfg_big_i,
   input  logic [NUM_WIN-1:0]    cfg_w16_i,
   input  logic [NUM_WIN*ADDR_W-1:0] cfg_base_i,
   input  logic [NUM_WIN*SIZE_W-1:0] cfg_size_i,
   input  logic [NUM_WIN*TW-1:0] cfg_timing_i,
   input  logic [NUM_WIN*BCW-1:0] cfg_burst_i,
   output logic [NUM_WIN-1:0]    cs_o,
   output logic                  hit_o,
   output logic [IDX_W-1:0]      win_o,
   output logic                  err_o,
   output logic [TW-1:0]         timing_o,
   output logic                  w16_o,
   output logic                  big_o,
   output logic [BLW-1:0]        burst_len_o
);
   if (NUM_WIN < 2) begin : g_bad_num
      $error("csel_decoder: NUM_WIN must be at least 2");
   end
   if (MIN_LOG2 >= ADDR_W) begin : g_bad_min
      $error("csel_decoder: MIN_LOG2 must be below ADDR_W");
   end
   if (ADDR_W > (1 << SIZE_W)) begin : g_bad_size
      $error("csel_decoder: SIZE_W too narrow for ADDR_W");
   end

   logic [NUM_WIN-1:0] match;
   csel_attr_t         attr_tab [NUM_WIN];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      csel_win_match #(
         .ADDR_W  (ADDR_W),
         .SIZE_W  (SIZE_W),
         .MIN_LOG2(MIN_LOG2)
      ) u_match (
         .addr_i (addr_i),
         .base_i (cfg_base_i[w*ADDR_W +: ADDR_W]),
         .size_i (cfg_size_i[w*SIZE_W +: SIZE_W]),
         .en_i   (cfg_en_i[w]),
         .match_o(match[w])
      );

      always_comb begin
         attr_tab[w].timing    = cfg_timing_i[w*TW +: TW];
         attr_tab[w].w16       = cfg_w16_i[w];
         attr_tab[w].burst_len = BLW'(1) << cfg_burst_i[w*BCW +: BCW];
      end

      if (w == 0) begin : g_fixed_order
         assign attr_tab[w].big = 1'b1;
      end else begin : g_cfg_order
         assign attr_tab[w].big = cfg_big_i[w];
      end
   end

   logic             any_hit;
   logic [IDX_W-1:0] pick;

   csel_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
      .match_i(match),
      .any_o  (any_hit),
      .idx_o  (pick)
   );

   logic               refuse;
   logic [NUM_WIN-1:0] cs_next;
   csel_attr_t         attr_sel;

   always_comb begin
      refuse   = any_hit && wr_i && cfg_wprot_i[pick];
      cs_next  = '0;
      if (any_hit && !refuse) cs_next[pick] = 1'b1;
      attr_sel = any_hit ? attr_tab[pick] : '0;
   end

   csel_attr_t attr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_o   <= '0;
         hit_o  <= 1'b0;
         win_o  <= '0;
         err_o  <= 1'b0;
         attr_q <= '0;
      end else if (req_i) begin
         cs_o   <= cs_next;
         hit_o  <= any_hit;
         win_o  <= any_hit ? pick : '0;
         err_o  <= !any_hit || refuse;
         attr_q <= attr_sel;
      end else begin
         cs_o   <= '0;
         hit_o  <= 1'b0;
         win_o  <= '0;
         err_o  <= 1'b0;
         attr_q <= '0;
      end
   end

   assign timing_o    = attr_q.timing;
   assign w16_o       = attr_q.w16;
   assign big_o       = attr_q.big;
   assign burst_len_o = attr_q.burst_len;
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
   parameter int NUM_WIN = 8,
   parameter int IDX_W   = 3,
   parameter int BLW     = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_i,
   input logic               wr_i,
   input logic [NUM_WIN-1:0] cs_o,
   input logic               hit_o,
   input logic [IDX_W-1:0]   win_o,
   input logic               err_o,
   input logic               big_o,
   input logic [BLW-1:0]     burst_len_o
);
   // R6
   cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(cs_o));

   // R6
   cs_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_o != '0) |-> (hit_o && !err_o && cs_o[win_o]));

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(req_i) |-> (cs_o == '0 && !hit_o && !err_o));

   // R4
   err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> $past(req_i));

   // R7
   refused_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && hit_o) |-> ($past(wr_i) && cs_o == '0));

   // R9
   win0_big_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && win_o == '0) |-> big_o);

   // R10
   burst_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> ($countones(burst_len_o) == 1));
endmodule

bind csel_decoder csel_decoder_chk #(
   .NUM_WIN(NUM_WIN),
   .IDX_W  (IDX_W),
   .BLW    (BLW)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_i      (req_i),
   .wr_i       (wr_i),
   .cs_o       (cs_o),
   .hit_o      (hit_o),
   .win_o      (win_o),
   .err_o      (err_o),
   .big_o      (big_o),
   .burst_len_o(burst_len_o)
);

// File: tb/csel_decoder_bench.sv
`timescale 1ns/1ps
module csel_decoder_bench;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req = 1'b0, wr = 1'b0;
   logic [31:0]   addr = '0;
   logic [N-1:0]  en_a, wp_a, big_a, w16_a;
   logic [31:0]   base_a [N];
   logic [4:0]    size_a [N];
   logic [1:0]    tim_a  [N];
   logic [1:0]    bur_a  [N];

   logic [N*32-1:0] cfg_base;
   logic [N*5-1:0]  cfg_size;
   logic [N*2-1:0]  cfg_tim, cfg_bur;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         cfg_base[i*32 +: 32] = base_a[i];
         cfg_size[i*5 +: 5]   = size_a[i];
         cfg_tim[i*2 +: 2]    = tim_a[i];
         cfg_bur[i*2 +: 2]    = bur_a[i];
      end
   end

   logic [N-1:0] cs;
   logic         hit, err, w16, big;
   logic [2:0]   win;
   logic [1:0]   tim;
   logic [3:0]   blen;

   csel_decoder u_csel_decoder (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
      .cfg_en_i(en_a), .cfg_wprot_i(wp_a), .cfg_big_i(big_a), .cfg_w16_i(w16_a),
      .cfg_base_i(cfg_base), .cfg_size_i(cfg_size), .cfg_timing_i(cfg_tim),
      .cfg_burst_i(cfg_bur), .cs_o(cs), .hit_o(hit), .win_o(win), .err_o(err),
      .timing_o(tim), .w16_o(w16), .big_o(big), .burst_len_o(blen)
   );

   int checks = 0, errors = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, addr, act, exp);
      end
   endtask

   function automatic int span(input int i);
      int s = int'(size_a[i]);
      if (s < 16) s = 16;
      if (s > 31) s = 31;
      return s;
   endfunction

   // R2 R3 R4 R5 model: lowest enabled window whose block number matches
   function automatic int expect_win(input logic [31:0] a);
      for (int i = 0; i < N; i++) begin
         int s = span(i);
         if (en_a[i] && ((longint'(a) >> s) == (longint'(base_a[i]) >> s))) return i;
      end
      return -1;
   endfunction

   task automatic access(input logic [31:0] a, input logic w);
      int e;
      @(negedge clk);
      req = 1'b1; addr = a; wr = w;
      e = expect_win(a);
      @(negedge clk);
      req = 1'b0;
      if (e < 0) begin
         // R4 miss
         check(err && !hit && cs == '0, "R4_miss", {cs, hit, err}, 1);
         check({tim, w16, big, blen} == '0, "R4_attr_zero", {tim, w16, big, blen}, 0);
      end else begin
         logic refuse = w && wp_a[e];
         // R5 lowest index selected
         check(hit && win == 3'(e), "R5_index", win, e);
         if (refuse) begin
            // R7 refused write
            check(err && cs == '0, "R7_refuse", {cs, err}, 1);
         end else begin
            // R6 one-hot select
            check(!err && cs == N'(1) << e, "R6_cs", cs, 1 << e);
         end
         // R8 width and timing
         check(w16 == w16_a[e] && tim == tim_a[e], "R8_attr", {tim, w16}, {tim_a[e], w16_a[e]});
         // R9 byte order
         check(big == ((e == 0) ? 1'b1 : big_a[e]), "R9_order", big, (e == 0) ? 1 : big_a[e]);
         // R10 burst length
         check(blen == (4'd1 << bur_a[e]), "R10_burst", blen, 1 << bur_a[e]);
      end
      @(negedge clk);
      // R1 idle cycle after the request
      check(cs == '0 && !hit && !err, "R1_idle", {cs, hit, err}, 0);
   endtask

   task automatic sweep_window(input int i);
      int s = span(i);
      longint lo = (longint'(base_a[i]) >> s) << s;
      longint hi = lo + (longint'(1) << s) - 1;
      for (int w = 0; w < 2; w++) begin
         access(32'(lo), w[0]);
         access(32'(hi), w[0]);
         access(32'(lo - 1), w[0]);
         access(32'(hi + 1), w[0]);
         access(32'(lo + (longint'(1) << (s - 1)) + 3), w[0]);
      end
   endtask

   initial begin
      en_a  = 8'b0111_0111;   // windows 3 and 7 disabled
      wp_a  = 8'b0010_0100;   // windows 2 and 5 refuse writes
      big_a = 8'b1010_0000;   // bit 0 clear, yet window 0 stays big
      w16_a = 8'b0101_0011;
      base_a[0] = 32'h0000_0000; size_a[0] = 5'd20; tim_a[0] = 2'd1; bur_a[0] = 2'd3;
      base_a[1] = 32'h0008_0000; size_a[1] = 5'd16; tim_a[1] = 2'd2; bur_a[1] = 2'd1;
      base_a[2] = 32'h1000_1234; size_a[2] = 5'd16; tim_a[2] = 2'd3; bur_a[2] = 2'd2; // R3 stray low bits
      base_a[3] = 32'h2000_0000; size_a[3] = 5'd24; tim_a[3] = 2'd0; bur_a[3] = 2'd0;
      base_a[4] = 32'h2000_0000; size_a[4] = 5'd28; tim_a[4] = 2'd1; bur_a[4] = 2'd0;
      base_a[5] = 32'h8000_0000; size_a[5] = 5'd31; tim_a[5] = 2'd2; bur_a[5] = 2'd3;
      base_a[6] = 32'h4000_0000; size_a[6] = 5'd3;  tim_a[6] = 2'd3; bur_a[6] = 2'd1; // clamps to 64 KB
      base_a[7] = 32'h5000_0000; size_a[7] = 5'd16; tim_a[7] = 2'd0; bur_a[7] = 2'd2;

      repeat (3) @(negedge clk);
      // R11 reset state
      check(cs == '0 && !hit && !err && win == '0 && blen == '0, "R11_reset", {cs, hit, err}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < N; i++) sweep_window(i);

      // R2 coarse sweep across the whole space
      for (int k = 0; k < 64; k++) begin
         access((32'(k) << 26) | (32'(k) * 32'h0001_3579), k[0]);
      end

      // R5 drop window 0 so the overlapped window 1 becomes visible
      @(negedge clk);
      en_a[0] = 1'b0;
      sweep_window(1);
      sweep_window(0);

      // R4 enable window 3: it now shadows window 4
      @(negedge clk);
      en_a[3] = 1'b1;
      sweep_window(3);
      sweep_window(4);

      // R9 window 0 back on with little endian requested
      @(negedge clk);
      en_a[0] = 1'b1;
      big_a[0] = 1'b0;
      access(32'h0000_4000, 1'b0);
      access(32'h0000_4000, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule